// File: doc/BRIEF.md
# Address-Window Chip Select Decoder with Wait-State Acknowledge

The block watches a 24-bit bus address and an active-low address strobe. It drives one of four active-low select lines when the address of a strobed cycle falls inside that line's window. Each window is set by an 11-bit base value and an 11-bit don't-care mask applied to address bits 23..13. A window is therefore always a power of two in size, at least 8 KB, and starts on a multiple of its own size.

For each window, software can also ask the block to end the bus cycle itself. The block then drives an active-low acknowledge after a programmable number of wait states, so no external cycle-termination logic is needed. Software configures the four channels through a small register port. Each channel has one 32-bit word, and any word can be read back at any time.

Top module: `csel_top`

## Requirements
- R1: Each channel i (reg_sel = i) holds one word: base in bits 10:0, mask in bits 21:11, enable in bit 22, acknowledge-enable in bit 23 and wait count in bits 27:24. Reading a word returns the fields last written, and bits 31:28 read as zero.
- R2: Only address bits 23..13 take part in decoding. Address bits 12..0 never change which select asserts.
- R3: A mask bit set to 1 removes the matching address bit from the compare. A bit whose mask bit is 0 must equal the base bit.
- R4: Call the first rising clock edge that samples as_n low E0. The winning cs_n line is low from E0 until the first edge that samples as_n high, and it goes high at that edge.
- R5: A channel whose enable bit is 0 never asserts its select or an acknowledge.
- R6: When several enabled channels match, only the lowest-numbered one asserts, and its wait count and acknowledge-enable are the ones used.
- R7: When the winning channel has acknowledge-enable = 1 and wait count W, ack_n goes low at edge E0+W+1.
- R8: Once low, ack_n stays low until the edge that samples as_n high, and it goes high at that edge.
- R9: When the winning channel has acknowledge-enable = 0, ack_n stays high for the whole cycle, while its select still asserts.
- R10: Reset clears every configuration word to zero, so after reset no select asserts and every word reads zero.
- R11: A strobed cycle that matches no enabled channel leaves all cs_n lines and ack_n high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 24 | Bus address, stable while as_n is low |
| as_n | input | 1 | Active-low address strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Channel word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected word |
| cs_n | output | 4 | Active-low chip selects, bit i for channel i |
| ack_n | output | 1 | Active-low internal cycle acknowledge |

## Verification
The hardest case to reach is the priority case: two enabled windows that overlap and have different wait counts and acknowledge settings. It only shows up when both the select and the acknowledge timing are compared against the lower channel. The bench programs channel 1 to cover the same window as channel 0. It checks that channel 0's select and its two-wait acknowledge win, then disables channel 0 and checks that the same address now gives channel 1's select with no acknowledge. The longest wait count (15) is reached with a strobe held for twenty cycles, which also shows that the acknowledge is held.

// File: rtl/csel_pkg.sv
package csel_pkg;
    localparam int NCH    = 4;
    localparam int IDX_W  = $clog2(NCH);
    localparam int ADDR_W = 24;
    localparam int CMP_LO = 13;
    localparam int FLD_W  = ADDR_W - CMP_LO;
    localparam int WAIT_W = 4;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic [WAIT_W-1:0] waits;
        logic              ack_en;
        logic              en;
        logic [FLD_W-1:0]  mask;
        logic [FLD_W-1:0]  base;
    } chan_cfg_t;

    localparam int CFG_W = $bits(chan_cfg_t);

    function automatic logic [WORD_W-1:0] cfg_to_word(chan_cfg_t c);
        return {{(WORD_W-CFG_W){1'b0}}, c};
    endfunction

    function automatic chan_cfg_t word_to_cfg(logic [WORD_W-1:0] w);
        return chan_cfg_t'(w[CFG_W-1:0]);
    endfunction
endpackage

// File: rtl/csel_regs.sv
module csel_regs
    import csel_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr,
    input  logic [IDX_W-1:0]           sel,
    input  logic [WORD_W-1:0]          wdata,
    output logic [WORD_W-1:0]          rdata,
    output chan_cfg_t [NCH-1:0]        cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr) begin
            cfg[sel] <= word_to_cfg(wdata);
        end
    end

    assign rdata = cfg_to_word(cfg[sel]);

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_chk
            assert_reset_clears_R10: assert property (@(posedge clk)
                $past(rst) |-> !cfg[i].en);
        end
    endgenerate
endmodule

// File: rtl/csel_match.sv
module csel_match
    import csel_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    input  chan_cfg_t [NCH-1:0] cfg,
    output logic                hit,
    output logic [IDX_W-1:0]    win
);
    logic [NCH-1:0] hit_v;
    logic [FLD_W-1:0] upper;

    assign upper = addr[ADDR_W-1:CMP_LO];

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_cmp
            assign hit_v[i] = cfg[i].en &&
                (((upper ^ cfg[i].base) & ~cfg[i].mask) == '0);
        end
    endgenerate

    always_comb begin
        hit = 1'b0;
        win = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (hit_v[i]) begin
                hit = 1'b1;
                win = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/csel_ackgen.sv
module csel_ackgen
    import csel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              as_low,
    input  logic              ack_en,
    input  logic [WAIT_W-1:0] waits,
    output logic              ack
);
    logic              active;
    logic [WAIT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            ack    <= 1'b0;
        end else if (!as_low) begin
            active <= 1'b0;
            ack    <= 1'b0;
        end else if (start) begin
            active <= ack_en;
            cnt    <= waits;
            ack    <= 1'b0;
        end else if (active && !ack) begin
            if (cnt == '0) ack <= 1'b1;
            else           cnt <= cnt - 1'b1;
        end
    end

    assert_ack_held_R8: assert property (@(posedge clk) disable iff (rst)
        (ack && as_low) |=> ack);
    assert_ack_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(active));
endmodule

// File: rtl/csel_top.sv
module csel_top
    import csel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [23:0]       addr,
    input  logic              as_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [3:0]        cs_n,
    output logic              ack_n
);
    chan_cfg_t [NCH-1:0] cfg;
    logic                hit;
    logic [IDX_W-1:0]    win;
    logic                busy;
    logic [NCH-1:0]      cs_q;
    logic                as_low;
    logic                start;
    logic                ack;

    assign as_low = !as_n;
    assign start  = as_low && !busy;

    csel_regs u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .sel(reg_sel),
        .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg)
    );

    csel_match u_match (
        .addr(addr), .cfg(cfg), .hit(hit), .win(win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cs_q <= '0;
        end else if (!as_low) begin
            busy <= 1'b0;
            cs_q <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cs_q <= hit ? (NCH'(1) << win) : '0;
        end
    end

    csel_ackgen u_ack (
        .clk(clk), .rst(rst), .start(start), .as_low(as_low),
        .ack_en(hit && cfg[win].ack_en), .waits(cfg[win].waits),
        .ack(ack)
    );

    assign cs_n  = ~cs_q;
    assign ack_n = ~ack;

    assert_cs_after_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        (|(~cs_n)) |-> $past(!as_n));
    assert_cs_release_R4: assert property (@(posedge clk) disable iff (rst)
        as_n |=> (&cs_n));
    assert_single_select_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));
    assert_ack_with_select_R11: assert property (@(posedge clk) disable iff (rst)
        !ack_n |-> (|(~cs_n)));
endmodule

// File: tb/tb_csel_top.sv
module tb_csel_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [23:0] addr;
    logic        as_n;
    logic        reg_wr;
    logic [1:0]  reg_sel;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [3:0]  cs_n;
    logic        ack_n;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    csel_top dut (
        .clk(clk), .rst(rst), .addr(addr), .as_n(as_n),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cs_n(cs_n), .ack_n(ack_n)
    );

    // vector: {addr[23:0], channel[2:0] (4 = none), waits[4:0] (31 = no ack)}
    localparam logic [31:0] VEC [10] = '{
        {24'h000000, 3'd0, 5'd2},
        {24'h00FFFF, 3'd0, 5'd2},
        {24'h010000, 3'd4, 5'd31},
        {24'h020000, 3'd1, 5'd31},
        {24'h021FFF, 3'd1, 5'd31},
        {24'h022000, 3'd4, 5'd31},
        {24'h800000, 3'd2, 5'd15},
        {24'hFFFFFF, 3'd2, 5'd15},
        {24'h7FFFFF, 3'd4, 5'd31},
        {24'h040000, 3'd4, 5'd31}
    };

    function automatic logic [31:0] mkword(logic [10:0] base, logic [10:0] mask,
                                           logic en, logic acke, logic [3:0] w);
        return {4'b0, w, acke, en, mask, base};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_word(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic run_cycle(input logic [23:0] a, input int ch, input int w,
                             input string req);
        logic ok;
        logic [3:0] exp_cs;
        logic [3:0] bad_cs;
        logic bad_ack;
        ok = 1'b1;
        bad_cs = 4'h0;
        bad_ack = 1'b0;
        exp_cs = (ch < 4) ? ~(4'b1 << ch) : 4'hF;
        @(negedge clk);
        addr = a; as_n = 1'b0;
        for (int j = 0; j < 20; j++) begin
            logic exp_ack;
            @(posedge clk);
            @(negedge clk);
            exp_ack = (ch < 4 && w != 31 && j >= w + 1) ? 1'b0 : 1'b1;
            if (cs_n != exp_cs) begin ok = 1'b0; bad_cs = cs_n; end
            if (ack_n != exp_ack) begin ok = 1'b0; bad_ack = ack_n; end
        end
        chk(ok, req, {bad_cs, 3'b0, bad_ack}, {exp_cs, 4'b0});
        as_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(cs_n == 4'hF && ack_n == 1'b1, "R4 R8 release",
            {cs_n, 3'b0, ack_n}, {4'hF, 4'h1});
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; addr = '0; as_n = 1'b1;
        reg_wr = 1'b0; reg_sel = '0; reg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        for (int i = 0; i < 4; i++) begin
            reg_sel = 2'(i);
            #1;
            chk(reg_rdata == 32'h0, "R10 reset readback", reg_rdata, 32'h0);
        end
        chk(cs_n == 4'hF && ack_n, "R10 idle outputs", {cs_n, 3'b0, ack_n}, 32'hF1);
        run_cycle(24'h000000, 4, 31, "R10 no select before config");

        // configuration
        wr_word(2'd0, mkword(11'h000, 11'h007, 1'b1, 1'b1, 4'd2));
        wr_word(2'd1, mkword(11'h010, 11'h000, 1'b1, 1'b0, 4'd0));
        wr_word(2'd2, mkword(11'h400, 11'h3FF, 1'b1, 1'b1, 4'd15));
        wr_word(2'd3, mkword(11'h020, 11'h000, 1'b0, 1'b1, 4'd5));

        // R1: readback, upper bits zero even if written
        wr_word(2'd3, 32'hF000_0000 | mkword(11'h020, 11'h000, 1'b0, 1'b1, 4'd5));
        reg_sel = 2'd3; #1;
        chk(reg_rdata == mkword(11'h020, 11'h000, 1'b0, 1'b1, 4'd5), "R1 readback ch3",
            reg_rdata, mkword(11'h020, 11'h000, 1'b0, 1'b1, 4'd5));
        reg_sel = 2'd2; #1;
        chk(reg_rdata == mkword(11'h400, 11'h3FF, 1'b1, 1'b1, 4'd15), "R1 readback ch2",
            reg_rdata, mkword(11'h400, 11'h3FF, 1'b1, 1'b1, 4'd15));

        // table walk: R2 R3 R5 R7 R8 R9 R11
        for (int v = 0; v < 10; v++) begin
            run_cycle(VEC[v][31:8], int'(VEC[v][7:5]), int'(VEC[v][4:0]),
                      "R2 R3 R5 R7 R9 R11 vector");
        end

        // R6: overlap channel 1 onto channel 0's window
        wr_word(2'd1, mkword(11'h000, 11'h007, 1'b1, 1'b0, 4'd0));
        run_cycle(24'h004000, 0, 2, "R6 lowest channel wins");
        wr_word(2'd0, mkword(11'h000, 11'h007, 1'b0, 1'b1, 4'd2));
        run_cycle(24'h004000, 1, 31, "R6 R9 next channel after disable");

        // R7: zero waits acknowledge one edge after E0
        wr_word(2'd1, mkword(11'h000, 11'h007, 1'b1, 1'b1, 4'd0));
        run_cycle(24'h000000, 1, 0, "R7 zero waits");

        // R5: enable channel 3 to show its window now decodes
        wr_word(2'd3, mkword(11'h020, 11'h000, 1'b1, 1'b1, 4'd5));
        run_cycle(24'h040123, 3, 5, "R5 R7 enabled ch3");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule